// File: doc/BRIEF.md
# Two-Wire Handshake Transfer Controller

This block moves one parallel data word at a time between two units that run on unrelated clocks. Two control wires carry the transfer. A valid wire runs from the sending side to the receiving side. An accept wire runs back the other way. Each transfer passes through four states: valid rises, accept rises, valid falls, and accept falls.

The block holds a sender controller and a receiver controller. The link wires appear as ports, so the two halves can sit on opposite sides of a boundary. The sender takes words from a local valid/ready request port. It puts the word on the link data bus and then raises valid. The receiver latches the bus word once it sees valid through a synchronizer. It then raises accept and presents the word on a one-cycle output strobe.

Each side has a watchdog. If its part of a transfer stalls for longer than a parameter number of its own clock cycles, that side drops its control wire and returns to idle. It also sets a sticky error flag, which stays set until a clear input is pulsed. This lets a faulty or missing partner unit be detected.

Top module: `hs_link_pair`

## Requirements
- R1: While reset is held, tx_valid, rx_ack, out_valid, src_err and dst_err are 0 and req_ready is 1.
- R2: tx_data already holds the word in the cycle before tx_valid rises, and it stays unchanged for as long as tx_valid stays high.
- R3: A request is taken on a src_clk edge where req_valid and req_ready are both 1. req_ready is 0 from that edge until the transfer has ended.
- R4: Every word taken by the sender appears on out_data exactly once, in the order the words were taken. out_valid is high for exactly one dst_clk cycle per word.
- R5: The receiver raises rx_ack on the same dst_clk edge that raises out_valid for the latched word.
- R6: Unless its watchdog expires, the sender keeps tx_valid high until it has seen tx_ack_in high through its synchronizer.
- R7: Unless its watchdog expires, the receiver keeps rx_ack high until it has seen rx_valid_in low through its synchronizer.
- R8: If the sender's transfer does not end within SRC_TIMEOUT src_clk cycles of tx_valid rising, the sender drops tx_valid, sets src_err and returns to idle. src_err stays 0 while the transfer is still inside that window.
- R9: If rx_valid_in stays high for DST_TIMEOUT dst_clk cycles after rx_ack rises, the receiver drops rx_ack and sets dst_err. It accepts no further word until it has seen rx_valid_in low.
- R10: src_err and dst_err are sticky. Each one clears only on a cycle of its own clock where its clear input (src_err_clr or dst_err_clr) is 1.
- R11: A new transfer starts only after both control lines are low. While the synchronized tx_ack_in is high, req_ready is 0 and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sender clock |
| src_rst | input | 1 | Sender synchronous reset, active high |
| req_valid | input | 1 | Local request holds a word |
| req_data | input | DATA_W | Local request word |
| req_ready | output | 1 | Sender can take a request |
| src_err | output | 1 | Sticky sender timeout flag |
| src_err_clr | input | 1 | Clears src_err |
| tx_valid | output | 1 | Link valid wire, driven by the sender |
| tx_data | output | DATA_W | Link data bus, driven by the sender |
| tx_ack_in | input | 1 | Link accept wire, as seen at the sender |
| dst_clk | input | 1 | Receiver clock |
| dst_rst | input | 1 | Receiver synchronous reset, active high |
| rx_valid_in | input | 1 | Link valid wire, as seen at the receiver |
| rx_data_in | input | DATA_W | Link data bus, as seen at the receiver |
| rx_ack | output | 1 | Link accept wire, driven by the receiver |
| out_valid | output | 1 | One-cycle strobe for a delivered word |
| out_data | output | DATA_W | Delivered word |
| dst_err | output | 1 | Sticky receiver timeout flag |
| dst_err_clr | input | 1 | Clears dst_err |

## Verification
The properties check the following on every cycle:
- the data bus holds still while valid is high;
- the sender is never ready while valid is high;
- the output strobe lasts one cycle and coincides with accept rising;
- the error flags are sticky;
- a timeout always drops the side's own control wire.

Some behaviour needs multi-cycle scenarios, so only the bench shows it:
- end-to-end ordering and delivery across the two clocks;
- the timeout window itself;
- blocking of new requests while accept is held high;
- the receiver refusing to re-accept until valid has gone low.

The bench covers these by cutting or forcing the link wires.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE     = 2'd0,
        SRC_SETUP    = 2'd1,
        SRC_WAIT_ACK = 2'd2,
        SRC_WAIT_REL = 2'd3
    } src_state_e;

    typedef enum logic [0:0] {
        DST_IDLE = 1'b0,
        DST_HOLD = 1'b1
    } dst_state_e;

    // counter width able to hold values 0..limit
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic logic src_waiting(input src_state_e st);
        return (st == SRC_WAIT_ACK) || (st == SRC_WAIT_REL);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hs_timeout.sv
module hs_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int W = hs_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + W'(1);
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl
    import hs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          link_valid,
    output logic [DW-1:0] link_data,
    input  logic          link_ack,
    output logic          err,
    input  logic          err_clr
);
    src_state_e    state;
    logic          ack_s;
    logic          tmo;
    logic          valid_q;
    logic          err_q;
    logic [DW-1:0] data_q;

    hs_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(clk), .rst(rst), .d(link_ack), .q(ack_s)
    );

    hs_timeout #(.LIMIT(TIMEOUT_CYC)) tmr_i (
        .clk(clk), .rst(rst), .run(src_waiting(state)), .expired(tmo)
    );

    assign req_ready  = (state == SRC_IDLE) && !ack_s;
    assign link_valid = valid_q;
    assign link_data  = data_q;
    assign err        = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SRC_IDLE;
            valid_q <= 1'b0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (tmo)          err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;

            unique case (state)
                SRC_IDLE: begin
                    if (req_valid && req_ready) begin
                        data_q <= req_data;
                        state  <= SRC_SETUP;
                    end
                end
                SRC_SETUP: begin
                    valid_q <= 1'b1;
                    state   <= SRC_WAIT_ACK;
                end
                SRC_WAIT_ACK: begin
                    if (ack_s) begin
                        valid_q <= 1'b0;
                        state   <= SRC_WAIT_REL;
                    end else if (tmo) begin
                        valid_q <= 1'b0;
                        state   <= SRC_IDLE;
                    end
                end
                SRC_WAIT_REL: begin
                    if (!ack_s || tmo) state <= SRC_IDLE;
                end
                default: state <= SRC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl
    import hs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          link_valid,
    input  logic [DW-1:0] link_data,
    output logic          link_ack,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          err,
    input  logic          err_clr
);
    dst_state_e    state;
    logic          valid_s;
    logic          tmo;
    logic          armed;
    logic          ack_q;
    logic          strobe_q;
    logic          err_q;
    logic [DW-1:0] word_q;

    hs_sync #(.STAGES(SYNC_STAGES)) valid_sync_i (
        .clk(clk), .rst(rst), .d(link_valid), .q(valid_s)
    );

    hs_timeout #(.LIMIT(TIMEOUT_CYC)) tmr_i (
        .clk(clk), .rst(rst), .run(state == DST_HOLD), .expired(tmo)
    );

    assign link_ack  = ack_q;
    assign out_valid = strobe_q;
    assign out_data  = word_q;
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DST_IDLE;
            armed    <= 1'b0;
            ack_q    <= 1'b0;
            strobe_q <= 1'b0;
            err_q    <= 1'b0;
            word_q   <= '0;
        end else begin
            if (tmo)          err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;

            if (tmo)          armed <= 1'b0;
            else if (!valid_s) armed <= 1'b1;

            strobe_q <= 1'b0;

            unique case (state)
                DST_IDLE: begin
                    if (valid_s && armed) begin
                        word_q   <= link_data;
                        strobe_q <= 1'b1;
                        ack_q    <= 1'b1;
                        state    <= DST_HOLD;
                    end
                end
                DST_HOLD: begin
                    if (!valid_s || tmo) begin
                        ack_q <= 1'b0;
                        state <= DST_IDLE;
                    end
                end
                default: state <= DST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_link_pair.sv
module hs_link_pair #(
    parameter int DATA_W      = 8,
    parameter int SRC_TIMEOUT = 64,
    parameter int DST_TIMEOUT = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              src_err,
    input  logic              src_err_clr,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ack_in,
    input  logic              dst_clk,
    input  logic              dst_rst,
    input  logic              rx_valid_in,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic              rx_ack,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              dst_err,
    input  logic              dst_err_clr
);
    hs_src_ctrl #(
        .DW(DATA_W), .TIMEOUT_CYC(SRC_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)
    ) src_i (
        .clk(src_clk), .rst(src_rst),
        .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
        .link_valid(tx_valid), .link_data(tx_data), .link_ack(tx_ack_in),
        .err(src_err), .err_clr(src_err_clr)
    );

    hs_dst_ctrl #(
        .DW(DATA_W), .TIMEOUT_CYC(DST_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)
    ) dst_i (
        .clk(dst_clk), .rst(dst_rst),
        .link_valid(rx_valid_in), .link_data(rx_data_in), .link_ack(rx_ack),
        .out_valid(out_valid), .out_data(out_data),
        .err(dst_err), .err_clr(dst_err_clr)
    );
endmodule

// File: rtl/hs_link_checker.sv
module hs_link_checker #(
    parameter int DATA_W = 8
) (
    input logic              src_clk,
    input logic              src_rst,
    input logic              req_ready,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              src_err,
    input logic              src_err_clr,
    input logic              dst_clk,
    input logic              dst_rst,
    input logic              rx_ack,
    input logic              out_valid,
    input logic              dst_err,
    input logic              dst_err_clr
);
    AST_TX_DATA_HELD: assert property (@(posedge src_clk) disable iff (src_rst)
        tx_valid && $past(tx_valid) |-> $stable(tx_data));                  // R2
    AST_TX_DATA_FIRST: assert property (@(posedge src_clk) disable iff (src_rst)
        $rose(tx_valid) |-> $stable(tx_data));                              // R2
    AST_READY_ONLY_IDLE: assert property (@(posedge src_clk) disable iff (src_rst)
        req_ready |-> !tx_valid);                                           // R3
    AST_SRC_TMO_DROPS_VALID: assert property (@(posedge src_clk) disable iff (src_rst)
        $rose(src_err) |-> !tx_valid);                                      // R8
    AST_SRC_ERR_STICKY: assert property (@(posedge src_clk) disable iff (src_rst)
        src_err && !src_err_clr |=> src_err);                               // R10
    AST_STROBE_SINGLE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        out_valid |=> !out_valid);                                          // R4
    AST_ACK_WITH_STROBE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $rose(rx_ack) |-> out_valid);                                       // R5
    AST_DST_TMO_DROPS_ACK: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $rose(dst_err) |-> !rx_ack);                                        // R9
    AST_DST_ERR_STICKY: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_err && !dst_err_clr |=> dst_err);                               // R10
endmodule

bind hs_link_pair hs_link_checker #(.DATA_W(DATA_W)) chk_i (
    .src_clk(src_clk), .src_rst(src_rst), .req_ready(req_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .src_err(src_err),
    .src_err_clr(src_err_clr), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .rx_ack(rx_ack), .out_valid(out_valid), .dst_err(dst_err),
    .dst_err_clr(dst_err_clr)
);

// File: tb/hs_link_pair_tb_top.sv
`timescale 1ns/1ps
module hs_link_pair_tb_top;
    localparam int DW  = 8;
    localparam int TMO = 40;

    logic src_clk = 1'b0, dst_clk = 1'b0;
    logic src_rst = 1'b1, dst_rst = 1'b1;
    logic req_valid = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, src_err, tx_valid, tx_ack_in;
    logic src_err_clr = 1'b0, dst_err_clr = 1'b0;
    logic [DW-1:0] tx_data, out_data;
    logic rx_valid_in, rx_ack, out_valid, dst_err;

    logic cut_ack = 1'b0, force_ack_hi = 1'b0, force_valid_hi = 1'b0;

    assign rx_valid_in = force_valid_hi ? 1'b1 : tx_valid;
    assign tx_ack_in   = force_ack_hi ? 1'b1 : (cut_ack ? 1'b0 : rx_ack);

    always #5 src_clk = ~src_clk;
    always #7 dst_clk = ~dst_clk;

    hs_link_pair #(.DATA_W(DW), .SRC_TIMEOUT(TMO), .DST_TIMEOUT(TMO), .SYNC_STAGES(2)) dut_i (
        .src_clk(src_clk), .src_rst(src_rst), .req_valid(req_valid), .req_data(req_data),
        .req_ready(req_ready), .src_err(src_err), .src_err_clr(src_err_clr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack_in(tx_ack_in),
        .dst_clk(dst_clk), .dst_rst(dst_rst), .rx_valid_in(rx_valid_in), .rx_data_in(tx_data),
        .rx_ack(rx_ack), .out_valid(out_valid), .out_data(out_data),
        .dst_err(dst_err), .dst_err_clr(dst_err_clr)
    );

    int n_vec = 0, n_bad = 0, src_cycles = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] last_word = '0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
        end
    endtask

    // driver: hands one word to the sender and records it as expected
    task automatic send(input logic [DW-1:0] w);
        @(negedge src_clk);
        req_valid = 1'b1;
        req_data  = w;
        while (!req_ready) @(negedge src_clk);
        @(posedge src_clk);
        exp_q.push_back(w);
        last_word = w;
        @(negedge src_clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R3", "ready after take", req_ready, 0);
    endtask

    task automatic drain();
        int k = 0;
        while (exp_q.size() != 0 && k < 2000) begin
            @(negedge src_clk);
            k++;
        end
        repeat (20) @(negedge src_clk);
        chk(exp_q.size() == 0, "R4", "words outstanding", exp_q.size(), 0);
    endtask

    // monitor: compares every strobe against the scoreboard
    always @(negedge dst_clk) begin
        if (!dst_rst && out_valid) begin
            chk(rx_ack == 1'b1, "R5", "ack with strobe", rx_ack, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected word", out_data, 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R4", "delivered word", out_data, e);
            end
        end
    end

    always @(posedge src_clk) begin
        src_cycles++;
        if (!done && src_cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected <150000", src_cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge src_clk);
        // R1 reset state
        chk(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
        chk(rx_ack == 1'b0, "R1", "rx_ack", rx_ack, 0);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(src_err == 1'b0 && dst_err == 1'b0, "R1", "errors", {src_err, dst_err}, 0);
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        @(negedge dst_clk); dst_rst = 1'b0;
        @(negedge src_clk); src_rst = 1'b0;
        repeat (5) @(negedge src_clk);

        // R4 distinct patterns and a back-to-back run
        send(8'h00); send(8'hFF); send(8'hA5); send(8'h5A);
        drain();
        for (int i = 0; i < 20; i++) send(DW'(i * 13 + 7));
        drain();

        // R11 accept line held high blocks new requests
        force_ack_hi = 1'b1;
        repeat (5) @(negedge src_clk);
        req_valid = 1'b1; req_data = 8'h3C;
        repeat (10) @(negedge src_clk);
        chk(req_ready == 1'b0, "R11", "ready with ack high", req_ready, 0);
        chk(tx_valid == 1'b0, "R11", "valid with ack high", tx_valid, 0);
        req_valid = 1'b0;
        force_ack_hi = 1'b0;
        repeat (5) @(negedge src_clk);
        send(8'h3C);
        drain();

        // R8 sender timeout with the accept wire cut
        cut_ack = 1'b1;
        send(8'hC3);
        repeat (20) @(negedge src_clk);
        chk(src_err == 1'b0, "R8", "early error", src_err, 0);
        chk(tx_valid == 1'b1, "R6", "valid held", tx_valid, 1);
        chk(tx_data == 8'hC3, "R2", "bus held", tx_data, 8'hC3);
        chk(rx_ack == 1'b1, "R7", "ack held", rx_ack, 1);
        repeat (40) @(negedge src_clk);
        chk(src_err == 1'b1, "R8", "timeout error", src_err, 1);
        chk(tx_valid == 1'b0, "R8", "valid dropped", tx_valid, 0);
        chk(dst_err == 1'b0, "R8", "receiver error", dst_err, 0);
        cut_ack = 1'b0;
        drain();
        repeat (30) @(negedge src_clk);
        chk(src_err == 1'b1, "R10", "sticky src_err", src_err, 1);
        src_err_clr = 1'b1;
        @(negedge src_clk);
        src_err_clr = 1'b0;
        @(negedge src_clk);
        chk(src_err == 1'b0, "R10", "src_err cleared", src_err, 0);

        // R9 receiver timeout with valid stuck high
        exp_q.push_back(last_word);
        force_valid_hi = 1'b1;
        repeat (80) @(negedge dst_clk);
        chk(dst_err == 1'b1, "R9", "timeout error", dst_err, 1);
        chk(rx_ack == 1'b0, "R9", "ack dropped", rx_ack, 0);
        repeat (20) @(negedge dst_clk);
        chk(exp_q.size() == 0, "R9", "one word only", exp_q.size(), 0);
        chk(rx_ack == 1'b0, "R9", "no re-accept", rx_ack, 0);
        force_valid_hi = 1'b0;
        repeat (10) @(negedge dst_clk);
        chk(dst_err == 1'b1, "R10", "sticky dst_err", dst_err, 1);
        dst_err_clr = 1'b1;
        @(negedge dst_clk);
        dst_err_clr = 1'b0;
        @(negedge dst_clk);
        chk(dst_err == 1'b0, "R10", "dst_err cleared", dst_err, 0);

        // recovery after both faults
        send(8'h81); send(8'h7E);
        drain();
        chk(src_err == 1'b0 && dst_err == 1'b0, "R10", "no new errors", {src_err, dst_err}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule